// File: doc/BRIEF.md
# E1 Timeslot-16 Signaling Multiframe Inserter

This block sits in the transmit path of an E1 framer. It writes the overhead of the channel-associated-signaling multiframe into timeslot 16. The stream arrives one timeslot octet per valid cycle. The block counts timeslots 0..31 and frames 0..15 on its own. A multiframe start pulse, given with the octet that is timeslot 0 of frame 0, realigns both counters.

In timeslot 16 of frame 0, the block builds a new octet:
- The alignment nibble. It is normally zeros and can be inverted to ones for test.
- Three extra bits. They are taken from a setting, or passed through when they are disabled.
- The alarm Y bit. It follows an alarm status input, or a forced value when forcing is enabled.

In timeslot 16 of every other frame, the signaling octet passes through unchanged. All other timeslots also pass through unchanged. A timeslot-16-only all-ones command overrides all of the timeslot-16 content. A global all-ones command blanks every timeslot and overrides everything else. The output is registered, with one cycle of latency.

Top module: `e1_ts16_sig_ins`

## Requirements
- R1: After reset, `valid_o` is 0 and `data_o` is 8'h00.
- R2: `valid_o` equals `valid_i` one cycle later. When `valid_i` is 0, `data_o` keeps its previous value.
- R3: An octet with `mf_sync_i` high is timeslot 0 of frame 0. Each valid octet advances the timeslot count, which wraps from 31 to 0. Each timeslot wrap advances the frame count, which wraps from 15 to 0. Idle cycles do not advance either count. Frame 0 therefore recurs every 512 valid octets without a new pulse.
- R4: Bit 1 is the first transmitted bit and is `data[7]`; bit 8 is `data[0]`. In timeslot 16 of frame 0, bits 1-4 (`data[7:4]`) are 4'b0000 when `aln_inv_i` is 0.
- R5: With `aln_inv_i` = 1, those four bits are 4'b1111.
- R6: The extra bits are bits 5, 7 and 8 (`data[3]`, `data[1]`, `data[0]`) of timeslot 16, frame 0.
  - With `xbit_dis_i` = 0, they carry `xbit_val_i[2]`, `xbit_val_i[1]` and `xbit_val_i[0]`, in that order.
  - With `xbit_dis_i` = 1, they carry the input bits unchanged.
- R7: The Y bit is bit 6 (`data[2]`) of timeslot 16, frame 0.
  - It equals `y_alarm_i` when `y_force_en_i` is 0.
  - It equals `y_force_val_i` when `y_force_en_i` is 1.
- R8: When neither all-ones command is active, every octet other than timeslot 16 of frame 0 is output unchanged.
- R9: With `ts16_ais_i` = 1, timeslot 16 of every frame is 8'hFF. Other timeslots are not affected.
- R10: With `ais_i` = 1, every octet is 8'hFF, whatever the other controls are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input octet valid |
| data_i | input | 8 | Input timeslot octet, bit 1 in MSB |
| mf_sync_i | input | 1 | This octet is TS0 of multiframe frame 0 |
| aln_inv_i | input | 1 | Invert alignment nibble to 1111 |
| xbit_dis_i | input | 1 | Pass extra bits through instead of inserting |
| xbit_val_i | input | 3 | Extra bit values for bits 5, 7, 8 |
| y_alarm_i | input | 1 | Signaling multiframe alarm status |
| y_force_en_i | input | 1 | Force the Y bit |
| y_force_val_i | input | 1 | Forced Y bit value |
| ts16_ais_i | input | 1 | All ones in timeslot 16 only |
| ais_i | input | 1 | All ones in every timeslot |
| valid_o | output | 1 | Output octet valid |
| data_o | output | 8 | Output timeslot octet |

## Verification
The assertions check the following on every valid cycle:
- The counter steps and its wrap, and that the counters hold through idle cycles.
- The output latency, and that `data_o` holds when no octet arrives.
- Pass-through outside timeslot 16.
- Both all-ones overrides.
- The alignment nibble and the forced Y bit, whenever timeslot 16 of frame 0 goes by.

Some behaviour only the bench scenarios can show:
- The full cross of nibble inversion, extra-bit enable and value, and Y source, applied at a position reached by realignment.
- The recurrence of frame 0 after a free-running 512-octet multiframe, with idle gaps in the stream.

// File: rtl/e1_sig_pkg.sv
`timescale 1ns/1ps
package e1_sig_pkg;
  localparam int OCT_W = 8;

  typedef struct packed {
    logic       aln_inv;
    logic       xbit_dis;
    logic [2:0] xbit_val;
    logic       y_alarm;
    logic       y_force_en;
    logic       y_force_val;
    logic       ts16_ais;
    logic       ais;
  } sig_ctrl_t;

  // bit n (1 = first sent) maps to data[8-n]
  localparam int Y_IDX = 2;
  localparam int X5_IDX = 3;
  localparam int X7_IDX = 1;
  localparam int X8_IDX = 0;
endpackage

// File: rtl/e1_mf_pos.sv
`timescale 1ns/1ps
module e1_mf_pos #(
  parameter int NUM_TS = 32,
  parameter int MF_LEN = 16,
  parameter int SIG_TS = 16,
  parameter int TS_W   = $clog2(NUM_TS),
  parameter int FR_W   = $clog2(MF_LEN)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic            mf_sync_i,
  output logic [TS_W-1:0] ts_o,
  output logic [FR_W-1:0] fr_o,
  output logic            sig_slot_o,
  output logic            mf_head_o
);
  localparam logic [TS_W-1:0] TS_LAST = TS_W'(NUM_TS - 1);
  localparam logic [FR_W-1:0] FR_LAST = FR_W'(MF_LEN - 1);

  logic [TS_W-1:0] ts_q, ts_n;
  logic [FR_W-1:0] fr_q, fr_n;
  logic            ts_last;

  // position of the octet currently presented
  assign ts_o       = mf_sync_i ? '0 : ts_q;
  assign fr_o       = mf_sync_i ? '0 : fr_q;
  assign sig_slot_o = (ts_o == TS_W'(SIG_TS));
  assign mf_head_o  = (fr_o == '0);

  assign ts_last = (ts_o == TS_LAST);

  always_comb begin
    ts_n = ts_last ? '0 : ts_o + 1'b1;
    fr_n = fr_o;
    if (ts_last) fr_n = (fr_o == FR_LAST) ? '0 : fr_o + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ts_q <= '0;
      fr_q <= '0;
    end else if (valid_i) begin
      ts_q <= ts_n;
      fr_q <= fr_n;
    end
  end

  a_r3_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(ts_q) && $stable(fr_q));

  a_r3_sync_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && mf_sync_i |=> ts_q == TS_W'(1) && fr_q == '0);

  a_r3_ts_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !mf_sync_i && ts_q == TS_LAST |=> ts_q == '0);

  a_r3_frame_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !mf_sync_i && ts_q == TS_LAST && fr_q == FR_LAST |=> fr_q == '0);
endmodule

// File: rtl/e1_ts16_mux.sv
`timescale 1ns/1ps
module e1_ts16_mux
  import e1_sig_pkg::*;
(
  input  logic [OCT_W-1:0] data_i,
  input  logic             sig_slot_i,
  input  logic             mf_head_i,
  input  sig_ctrl_t        ctrl_i,
  output logic [OCT_W-1:0] data_o
);
  logic [OCT_W-1:0] ovh;

  always_comb begin
    ovh = data_i;
    ovh[OCT_W-1 -: 4] = {4{ctrl_i.aln_inv}};
    if (!ctrl_i.xbit_dis) begin
      ovh[X5_IDX] = ctrl_i.xbit_val[2];
      ovh[X7_IDX] = ctrl_i.xbit_val[1];
      ovh[X8_IDX] = ctrl_i.xbit_val[0];
    end
    ovh[Y_IDX] = ctrl_i.y_force_en ? ctrl_i.y_force_val : ctrl_i.y_alarm;
  end

  // priority: global AIS > TS16 AIS > frame-0 overhead > pass
  always_comb begin
    if (ctrl_i.ais)                          data_o = '1;
    else if (sig_slot_i && ctrl_i.ts16_ais)  data_o = '1;
    else if (sig_slot_i && mf_head_i)        data_o = ovh;
    else                                     data_o = data_i;
  end
endmodule

// File: rtl/e1_ts16_sig_ins.sv
`timescale 1ns/1ps
module e1_ts16_sig_ins
  import e1_sig_pkg::*;
#(
  parameter int NUM_TS = 32,
  parameter int MF_LEN = 16,
  parameter int SIG_TS = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  logic [7:0] data_i,
  input  logic       mf_sync_i,
  input  logic       aln_inv_i,
  input  logic       xbit_dis_i,
  input  logic [2:0] xbit_val_i,
  input  logic       y_alarm_i,
  input  logic       y_force_en_i,
  input  logic       y_force_val_i,
  input  logic       ts16_ais_i,
  input  logic       ais_i,
  output logic       valid_o,
  output logic [7:0] data_o
);
  localparam int TS_W = $clog2(NUM_TS);
  localparam int FR_W = $clog2(MF_LEN);

  sig_ctrl_t        ctrl;
  logic [TS_W-1:0]  cur_ts;
  logic [FR_W-1:0]  cur_fr;
  logic             sig_slot, mf_head;
  logic [OCT_W-1:0] mux_data;
  logic [OCT_W-1:0] data_q;
  logic             valid_q;

  assign ctrl = '{aln_inv: aln_inv_i, xbit_dis: xbit_dis_i, xbit_val: xbit_val_i,
                  y_alarm: y_alarm_i, y_force_en: y_force_en_i,
                  y_force_val: y_force_val_i, ts16_ais: ts16_ais_i, ais: ais_i};

  e1_mf_pos #(.NUM_TS(NUM_TS), .MF_LEN(MF_LEN), .SIG_TS(SIG_TS)) u_pos (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (valid_i),
    .mf_sync_i  (mf_sync_i),
    .ts_o       (cur_ts),
    .fr_o       (cur_fr),
    .sig_slot_o (sig_slot),
    .mf_head_o  (mf_head)
  );

  e1_ts16_mux u_mux (
    .data_i     (data_i),
    .sig_slot_i (sig_slot),
    .mf_head_i  (mf_head),
    .ctrl_i     (ctrl),
    .data_o     (mux_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) data_q <= mux_data;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;

  a_r2_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  a_r2_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o && $stable(data_o));

  a_r10_ais_all_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && ais_i |=> data_o == 8'hFF);

  a_r9_ts16_ais: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && sig_slot && ts16_ais_i |=> data_o == 8'hFF);

  a_r8_passthrough: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !sig_slot && !ais_i |=> data_o == $past(data_i));

  a_r4_align_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && sig_slot && mf_head && !ais_i && !ts16_ais_i && !aln_inv_i
    |=> data_o[7:4] == 4'h0);

  a_r5_align_inv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && sig_slot && mf_head && !ais_i && !ts16_ais_i && aln_inv_i
    |=> data_o[7:4] == 4'hF);

  a_r7_y_forced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && sig_slot && mf_head && !ais_i && !ts16_ais_i && y_force_en_i
    |=> data_o[2] == $past(y_force_val_i));
endmodule

// File: tb/e1_ts16_sig_ins_test.sv
`timescale 1ns/1ps
module e1_ts16_sig_ins_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid = 1'b0;
  logic [7:0] din = 8'h00;
  logic       mf_sync = 1'b0;
  logic       aln_inv = 1'b0, xbit_dis = 1'b0, y_alarm = 1'b0;
  logic       y_force_en = 1'b0, y_force_val = 1'b0, ts16_ais = 1'b0, ais = 1'b0;
  logic [2:0] xbit_val = 3'b000;
  logic       valid_o;
  logic [7:0] data_o;

  int n_tests = 0;
  int n_fail  = 0;
  int m_ts = 0;
  int m_fr = 0;
  int m_mf = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  e1_ts16_sig_ins uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .data_i(din), .mf_sync_i(mf_sync),
    .aln_inv_i(aln_inv), .xbit_dis_i(xbit_dis), .xbit_val_i(xbit_val),
    .y_alarm_i(y_alarm), .y_force_en_i(y_force_en), .y_force_val_i(y_force_val),
    .ts16_ais_i(ts16_ais), .ais_i(ais), .valid_o(valid_o), .data_o(data_o)
  );

  task automatic check(input bit ok, input string req, input logic [7:0] act,
                       input logic [7:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h (ts %0d fr %0d)", req, act, exp, m_ts, m_fr);
    end
  endtask

  // one valid octet; model position is that of this octet
  task automatic oct(input logic [7:0] d, input bit sync);
    logic [7:0] e;
    logic [7:0] ovh;
    bit head;
    @(negedge clk);
    valid = 1'b1; din = d; mf_sync = sync;
    if (sync) begin m_ts = 0; m_fr = 0; m_mf = 0; end
    head = (m_ts == 16) && (m_fr == 0);
    ovh = {{4{aln_inv}},
           xbit_dis ? d[3] : xbit_val[2],
           y_force_en ? y_force_val : y_alarm,
           xbit_dis ? d[1] : xbit_val[1],
           xbit_dis ? d[0] : xbit_val[0]};
    @(posedge clk); #1;
    if (ais) begin
      check(data_o == 8'hFF, "R10", data_o, 8'hFF);
    end else if (m_ts == 16 && ts16_ais) begin
      check(data_o == 8'hFF, "R9", data_o, 8'hFF);
    end else if (head) begin
      e = ovh;
      if (m_mf > 0) check(data_o[7:4] == e[7:4], "R3", data_o, e);
      else if (aln_inv) check(data_o[7:4] == e[7:4], "R5", data_o, e);
      else check(data_o[7:4] == e[7:4], "R4", data_o, e);
      check({data_o[3], data_o[1:0]} == {e[3], e[1:0]}, "R6", data_o, e);
      check(data_o[2] == e[2], "R7", data_o, e);
    end else begin
      check(data_o == d, "R8", data_o, d);
    end
    check(valid_o == 1'b1, "R2", {7'd0, valid_o}, 8'h01);
    m_ts++;
    if (m_ts == 32) begin
      m_ts = 0; m_fr++;
      if (m_fr == 16) begin m_fr = 0; m_mf++; end
    end
  endtask

  task automatic idle(input logic [7:0] junk);
    logic [7:0] prev;
    prev = data_o;
    @(negedge clk);
    valid = 1'b0; din = junk; mf_sync = 1'b0;
    @(posedge clk); #1;
    check(valid_o == 1'b0 && data_o == prev, "R2", data_o, prev);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(valid_o == 1'b0 && data_o == 8'h00, "R1", data_o, 8'h00);
    @(negedge clk); rst_n = 1'b1;

    // sweep all frame-0 TS16 control combinations, realigning each time (R3..R7)
    for (int cfg = 0; cfg < 256; cfg++) begin
      aln_inv     = cfg[0];
      xbit_dis    = cfg[1];
      xbit_val    = cfg[4:2];
      y_alarm     = cfg[5];
      y_force_en  = cfg[6];
      y_force_val = cfg[7];
      for (int t = 0; t < 17; t++) oct(8'(cfg * 29 + t * 53 + 1), t == 0);
      if (cfg % 16 == 5) idle(8'(cfg));
    end

    // free-running streams with gaps: normal (R3 wrap), TS16 AIS (R9), global AIS (R10)
    for (int mode = 0; mode < 3; mode++) begin
      aln_inv = mode[0]; xbit_dis = 1'b0; xbit_val = 3'b101;
      y_alarm = 1'b1; y_force_en = 1'b0;
      ts16_ais = (mode == 1);
      ais = (mode == 2);
      for (int i = 0; i < 1024; i++) begin
        oct(8'(i * 7 + mode * 91 + 3), i == 0);
        if (i % 37 == 11) idle(8'(i));
      end
    end
    ais = 1'b0; ts16_ais = 1'b0;
    idle(8'h5A);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule